// File: doc/BRIEF.md
# Card Management Register File with Write-Protect Gating

This block holds the small set of control registers that a memory card exposes in its attribute address space, reached over an 8-bit register bus. A host uses them to hold the card in a soft reset, to put selected flash device pairs into deep power-down, to record which socket and copy slot the card occupies, and to protect the common memory and the card-information region against writes. A read-only status register gathers bits from the other registers together with the live protect switch and the device ready lines, so that the host can learn the card state in one read.

The block also produces the qualifiers that the memory datapath uses: one write-enable for common memory, one for the card-information region, a block-locking enable, a soft reset level and one deep power-down line per device pair. The mechanical protect switch blocks every write to common and card-information memory, while the management registers themselves stay writable, so a host can always reconfigure protection. Registers sit on even byte addresses only. Read data is registered and appears one clock after the address.

Top module: `card_mgmt_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every register to 00h; after it `soft_rst`, `blk_lock_en` and every `pair_pd` bit are 0, and each mapped register reads 00h, except the live status bits.
- R2: The option register at 4000h holds the soft reset in bit 7 and drives `soft_rst` with it; a written 1 holds the reset level and a written 0 ends it. Bits 6..0 read as 0.
- R3: The configuration register at 4002h holds power-down in bit 2 (other bits read 0). The sleep register at 4118h holds one select bit per device pair in bits 0..5 (bit i is pair i, i.e. devices 2i and 2i+1; bits 7..6 read 0). `pair_pd[i]` is 1 exactly when power-down is 1 and sleep bit i is 1.
- R4: The socket/copy register at 4006h stores a socket number in bits 3..0 and a copy number in bits 6..4; bit 7 reads 0.
- R5: The write protection register at 4104h holds block-lock enable in bit 2 (drives `blk_lock_en`), common-memory protect in bit 1 and card-information protect in bit 0; bits 7..3 read 0. `cm_wr_ok` = not switch and not bit 1; `cis_wr_ok` = not switch and not bit 0.
- R6: With `wp_switch` = 1 both `cm_wr_ok` and `cis_wr_ok` are 0, yet writes to the management registers still take effect.
- R7: The status register at 4100h reads, from bit 7 to bit 0: OR of `dev_mask`, OR of the sleep bits, soft reset, common-memory protect, power-down, card-information protect, `wp_switch`, and ready, where ready is 1 exactly when every device is either ready (`dev_ready`) or masked (`dev_mask`).
- R8: The status register is read-only: a write to 4100h changes no register and no output.
- R9: Odd byte addresses and unmapped addresses (including addresses below 4000h) read as 00h, and writes to them change no register and no output.
- R10: `bus_rdata` shows the register selected by `bus_addr` at the previous rising clock edge, with the value it had before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high card reset |
| bus_addr | input | 15 | Attribute-space byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wp_switch | input | 1 | Mechanical protect switch, 1 = protected |
| dev_ready | input | 12 | Per-device ready, 1 = ready |
| dev_mask | input | 12 | Per-device ready mask, 1 = ignore device |
| soft_rst | output | 1 | Soft reset level |
| blk_lock_en | output | 1 | Block locking enable |
| cm_wr_ok | output | 1 | Common memory write permitted |
| cis_wr_ok | output | 1 | Card-information region write permitted |
| pair_pd | output | 6 | Deep power-down per device pair |

## Verification
The bench goes after the gating corners: a busy device hidden by its mask must leave ready at 1, while one unmasked busy device must pull it low, and a design that ANDed only `dev_ready` would report busy forever. Power-down is checked with sparse sleep masks, so a design that powered down every pair on the power-down bit would show extra `pair_pd` bits. Writes to the status address, to odd addresses and to the unmapped hole next to a register must leave every output and register intact, which catches decoders that ignore bit 0 or use too few offset bits. A write with the switch on must still land in the protection register, and a read in the same cycle as a write must return the old value, which catches a read port taken after the update.

// File: rtl/card_mgmt_pkg.sv
package card_mgmt_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned WIN_W  = 9;

    localparam logic [WIN_W-1:0] OFF_OPT   = 9'h000;
    localparam logic [WIN_W-1:0] OFF_CFG   = 9'h002;
    localparam logic [WIN_W-1:0] OFF_SOCK  = 9'h006;
    localparam logic [WIN_W-1:0] OFF_STAT  = 9'h100;
    localparam logic [WIN_W-1:0] OFF_WPROT = 9'h104;
    localparam logic [WIN_W-1:0] OFF_SLEEP = 9'h118;

    localparam logic [DATA_W-1:0] MASK_OPT   = 8'h80;
    localparam logic [DATA_W-1:0] MASK_CFG   = 8'h04;
    localparam logic [DATA_W-1:0] MASK_SOCK  = 8'h7F;
    localparam logic [DATA_W-1:0] MASK_WPROT = 8'h07;

    localparam int unsigned BIT_SRST   = 7;
    localparam int unsigned BIT_PWDN   = 2;
    localparam int unsigned BIT_BLKEN  = 2;
    localparam int unsigned BIT_CMPROT = 1;
    localparam int unsigned BIT_CISPRT = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OPT,
        SEL_CFG,
        SEL_SOCK,
        SEL_STAT,
        SEL_WPROT,
        SEL_SLEEP
    } cmr_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] opt;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] sock;
        logic [DATA_W-1:0] wprot;
        logic [DATA_W-1:0] sleep;
    } cmr_regs_t;

    function automatic logic [DATA_W-1:0] sleep_mask(input int unsigned pairs);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            if (i < pairs) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic cmr_sel_e offset_to_sel(input logic [WIN_W-1:0] off);
        cmr_sel_e s;
        case (off)
            OFF_OPT:   s = SEL_OPT;
            OFF_CFG:   s = SEL_CFG;
            OFF_SOCK:  s = SEL_SOCK;
            OFF_STAT:  s = SEL_STAT;
            OFF_WPROT: s = SEL_WPROT;
            OFF_SLEEP: s = SEL_SLEEP;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cmr_decode.sv
module cmr_decode
    import card_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 15'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    output cmr_sel_e          sel
);
    localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1 << WIN_W);

    logic [ADDR_W-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = addr - BASE_ADDR;
        in_window = (addr >= BASE_ADDR) && (offset < WIN_SIZE);
        if (in_window)
            sel = offset_to_sel(offset[WIN_W-1:0]);
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/cmr_store.sv
module cmr_store
    import card_mgmt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  cmr_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output cmr_regs_t         regs
);
    localparam logic [DATA_W-1:0] MASK_SLEEP = sleep_mask(NUM_PAIRS);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr) begin
            case (sel)
                SEL_OPT:   regs.opt   <= wdata & MASK_OPT;
                SEL_CFG:   regs.cfg   <= wdata & MASK_CFG;
                SEL_SOCK:  regs.sock  <= wdata & MASK_SOCK;
                SEL_WPROT: regs.wprot <= wdata & MASK_WPROT;
                SEL_SLEEP: regs.sleep <= wdata & MASK_SLEEP;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cmr_status.sv
module cmr_status
    import card_mgmt_pkg::*;
#(
    parameter int unsigned NUM_DEV = 12
) (
    input  cmr_regs_t          regs,
    input  logic               wp_switch,
    input  logic [NUM_DEV-1:0] dev_ready,
    input  logic [NUM_DEV-1:0] dev_mask,
    output logic [DATA_W-1:0]  status
);
    logic [NUM_DEV-1:0] dev_ok;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign dev_ok[d] = dev_ready[d] | dev_mask[d];
    end

    always_comb begin
        status[7] = |dev_mask;
        status[6] = |regs.sleep;
        status[5] = regs.opt[BIT_SRST];
        status[4] = regs.wprot[BIT_CMPROT];
        status[3] = regs.cfg[BIT_PWDN];
        status[2] = regs.wprot[BIT_CISPRT];
        status[1] = wp_switch;
        status[0] = &dev_ok;
    end
endmodule

// File: rtl/cmr_gating.sv
module cmr_gating
    import card_mgmt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 6
) (
    input  cmr_regs_t            regs,
    input  logic                 wp_switch,
    output logic                 soft_rst,
    output logic                 blk_lock_en,
    output logic                 cm_wr_ok,
    output logic                 cis_wr_ok,
    output logic [NUM_PAIRS-1:0] pair_pd
);
    logic pwdn;

    assign pwdn        = regs.cfg[BIT_PWDN];
    assign soft_rst    = regs.opt[BIT_SRST];
    assign blk_lock_en = regs.wprot[BIT_BLKEN];
    assign cm_wr_ok    = ~wp_switch & ~regs.wprot[BIT_CMPROT];
    assign cis_wr_ok   = ~wp_switch & ~regs.wprot[BIT_CISPRT];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign pair_pd[p] = pwdn & regs.sleep[p];
    end
endmodule

// File: rtl/card_mgmt_regs.sv
module card_mgmt_regs
    import card_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 15'h4000,
    parameter int unsigned NUM_PAIRS = 6,
    localparam int unsigned NUM_DEV  = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 wp_switch,
    input  logic [NUM_DEV-1:0]   dev_ready,
    input  logic [NUM_DEV-1:0]   dev_mask,
    output logic                 soft_rst,
    output logic                 blk_lock_en,
    output logic                 cm_wr_ok,
    output logic                 cis_wr_ok,
    output logic [NUM_PAIRS-1:0] pair_pd
);
    cmr_sel_e          sel;
    cmr_regs_t         regs;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rd_mux;

    cmr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    cmr_store #(.NUM_PAIRS(NUM_PAIRS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    cmr_status #(.NUM_DEV(NUM_DEV)) u_status (
        .regs      (regs),
        .wp_switch (wp_switch),
        .dev_ready (dev_ready),
        .dev_mask  (dev_mask),
        .status    (status)
    );

    cmr_gating #(.NUM_PAIRS(NUM_PAIRS)) u_gating (
        .regs        (regs),
        .wp_switch   (wp_switch),
        .soft_rst    (soft_rst),
        .blk_lock_en (blk_lock_en),
        .cm_wr_ok    (cm_wr_ok),
        .cis_wr_ok   (cis_wr_ok),
        .pair_pd     (pair_pd)
    );

    always_comb begin
        case (sel)
            SEL_OPT:   rd_mux = regs.opt;
            SEL_CFG:   rd_mux = regs.cfg;
            SEL_SOCK:  rd_mux = regs.sock;
            SEL_STAT:  rd_mux = status;
            SEL_WPROT: rd_mux = regs.wprot;
            SEL_SLEEP: rd_mux = regs.sleep;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/cmr_checker.sv
module cmr_checker
    import card_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 15'h4000,
    parameter int unsigned NUM_PAIRS = 6,
    parameter int unsigned NUM_DEV   = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 wp_switch,
    input logic                 soft_rst,
    input logic                 blk_lock_en,
    input logic                 cm_wr_ok,
    input logic                 cis_wr_ok,
    input logic [NUM_PAIRS-1:0] pair_pd
);
    localparam logic [ADDR_W-1:0] A_OPT  = BASE_ADDR + ADDR_W'(OFF_OPT);
    localparam logic [ADDR_W-1:0] A_CFG  = BASE_ADDR + ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFF_STAT);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) && !rst |-> !soft_rst && !blk_lock_en && pair_pd == '0 && bus_rdata == '0); // R1

    AST_SRST_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_OPT |=> soft_rst == $past(bus_wdata[BIT_SRST])); // R2

    AST_PD_OFF_WHEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_CFG && !bus_wdata[BIT_PWDN] |=> pair_pd == '0); // R3

    AST_SWITCH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        wp_switch |-> !cm_wr_ok && !cis_wr_ok); // R6

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_STAT |=> $stable({soft_rst, blk_lock_en, pair_pd})); // R8

    AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr[0] |=> $stable({soft_rst, blk_lock_en, pair_pd})); // R9

    AST_ODD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr[0] |=> bus_rdata == '0); // R9
endmodule

bind card_mgmt_regs cmr_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .NUM_PAIRS (NUM_PAIRS),
    .NUM_DEV   (NUM_DEV)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wp_switch   (wp_switch),
    .soft_rst    (soft_rst),
    .blk_lock_en (blk_lock_en),
    .cm_wr_ok    (cm_wr_ok),
    .cis_wr_ok   (cis_wr_ok),
    .pair_pd     (pair_pd)
);

// File: tb/tb_card_mgmt_regs.sv
`timescale 1ns/1ps
module tb_card_mgmt_regs;
    localparam int NP = 6;
    localparam int ND = 12;

    localparam logic [14:0] A_OPT   = 15'h4000;
    localparam logic [14:0] A_CFG   = 15'h4002;
    localparam logic [14:0] A_SOCK  = 15'h4006;
    localparam logic [14:0] A_STAT  = 15'h4100;
    localparam logic [14:0] A_WPROT = 15'h4104;
    localparam logic [14:0] A_SLEEP = 15'h4118;

    logic          clk = 1'b0;
    logic          rst;
    logic [14:0]   bus_addr;
    logic          bus_wr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    logic          wp_switch;
    logic [ND-1:0] dev_ready;
    logic [ND-1:0] dev_mask;
    logic          soft_rst, blk_lock_en, cm_wr_ok, cis_wr_ok;
    logic [NP-1:0] pair_pd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_opt, m_cfg, m_sock, m_wp, m_sleep;

    always #2 clk = ~clk;

    card_mgmt_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_switch(wp_switch),
        .dev_ready(dev_ready), .dev_mask(dev_mask), .soft_rst(soft_rst),
        .blk_lock_en(blk_lock_en), .cm_wr_ok(cm_wr_ok), .cis_wr_ok(cis_wr_ok),
        .pair_pd(pair_pd)
    );

    function automatic logic [7:0] exp_status();
        return {|dev_mask, |m_sleep, m_opt[7], m_wp[1], m_cfg[2], m_wp[0],
                wp_switch, &(dev_ready | dev_mask)};
    endfunction

    function automatic logic [7:0] exp_read(input logic [14:0] a);
        case (a)
            A_OPT:   return m_opt;
            A_CFG:   return m_cfg;
            A_SOCK:  return m_sock;
            A_STAT:  return exp_status();
            A_WPROT: return m_wp;
            A_SLEEP: return m_sleep;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [14:0] a);
        case (a)
            A_OPT:   return "R2";
            A_CFG:   return "R3";
            A_SOCK:  return "R4";
            A_STAT:  return "R7";
            A_WPROT: return "R5";
            A_SLEEP: return "R3";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [14:0] a, input logic [7:0] d);
        case (a)
            A_OPT:   m_opt   = d & 8'h80;
            A_CFG:   m_cfg   = d & 8'h04;
            A_SOCK:  m_sock  = d & 8'h7F;
            A_WPROT: m_wp    = d & 8'h07;
            A_SLEEP: m_sleep = d & 8'h3F;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [14:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        check(req, $sformatf("read %0h", a), 32'(bus_rdata), 32'(exp_read(a)));
    endtask

    task automatic check_outputs(input string req);
        logic [NP-1:0] epd;
        for (int p = 0; p < NP; p++) epd[p] = m_cfg[2] & m_sleep[p];
        check(req, "soft_rst", 32'(soft_rst), 32'(m_opt[7]));
        check(req, "blk_lock_en", 32'(blk_lock_en), 32'(m_wp[2]));
        check(req, "cm_wr_ok", 32'(cm_wr_ok), 32'(!wp_switch && !m_wp[1]));
        check(req, "cis_wr_ok", 32'(cis_wr_ok), 32'(!wp_switch && !m_wp[0]));
        check(req, "pair_pd", 32'(pair_pd), 32'(epd));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_opt = 0; m_cfg = 0; m_sock = 0; m_wp = 0; m_sleep = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [14:0] pool [10];
        logic [7:0] keep;
        void'($urandom(32'h5EED1234));
        pool[0] = A_OPT; pool[1] = A_CFG; pool[2] = A_SOCK; pool[3] = A_STAT;
        pool[4] = A_WPROT; pool[5] = A_SLEEP; pool[6] = 15'h4001;
        pool[7] = 15'h4004; pool[8] = 15'h4119; pool[9] = 15'h3FFE;

        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        wp_switch = 1'b0; dev_ready = '1; dev_mask = '0;
        m_opt = 0; m_cfg = 0; m_sock = 0; m_wp = 0; m_sleep = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "rdata after reset", 32'(bus_rdata), 32'h0);
        check_outputs("R1");
        do_read(A_OPT, "R1");
        do_read(A_SLEEP, "R1");
        do_read(A_STAT, "R1");

        // R2: soft reset hold and release
        do_write(A_OPT, 8'hFF);
        check("R2", "soft_rst set", 32'(soft_rst), 32'h1);
        do_read(A_OPT, "R2");
        do_write(A_OPT, 8'h7F);
        check("R2", "soft_rst cleared", 32'(soft_rst), 32'h0);

        // R3: power-down only on selected pairs
        do_write(A_SLEEP, 8'hE5);
        check("R3", "pd without pwdn", 32'(pair_pd), 32'h0);
        do_write(A_CFG, 8'hFF);
        check("R3", "pd sparse mask", 32'(pair_pd), 32'h25);
        do_read(A_CFG, "R3");
        do_read(A_SLEEP, "R3");
        do_write(A_CFG, 8'h00);
        check("R3", "pd released", 32'(pair_pd), 32'h0);

        // R4: socket/copy fields
        do_write(A_SOCK, 8'hDA);
        do_read(A_SOCK, "R4");

        // R5 and R6: protection and switch
        do_write(A_WPROT, 8'hFE);
        check_outputs("R5");
        @(negedge clk) wp_switch = 1'b1;
        do_write(A_WPROT, 8'h01);
        check("R6", "reg write with switch on", 32'(blk_lock_en), 32'h0);
        do_read(A_WPROT, "R6");
        check("R6", "cm_wr_ok switch", 32'(cm_wr_ok), 32'h0);
        check("R6", "cis_wr_ok switch", 32'(cis_wr_ok), 32'h0);
        @(negedge clk) wp_switch = 1'b0;
        #0.5 check("R5", "cm_wr_ok switch off", 32'(cm_wr_ok), 32'h1);

        // R7: ready aggregation with mask
        @(negedge clk) begin dev_ready = 12'hFF7; dev_mask = 12'h008; end
        do_read(A_STAT, "R7");
        check("R7", "masked busy ready bit", 32'(bus_rdata[0]), 32'h1);
        @(negedge clk) dev_mask = 12'h000;
        do_read(A_STAT, "R7");
        check("R7", "unmasked busy ready bit", 32'(bus_rdata[0]), 32'h0);
        @(negedge clk) dev_ready = '1;

        // R8: status write ignored
        keep = exp_status();
        do_write(A_STAT, 8'hFF);
        check_outputs("R8");
        do_read(A_STAT, "R8");
        check("R8", "status unchanged", 32'(bus_rdata), 32'(keep));

        // R9: odd / hole writes ignored
        do_write(15'h4001, 8'hFF);
        do_write(15'h4004, 8'hFF);
        do_write(15'h4119, 8'hFF);
        check_outputs("R9");
        do_read(15'h4001, "R9");
        do_read(15'h4005, "R9");
        do_read(A_OPT, "R9");
        do_read(A_SLEEP, "R9");

        // R10: read in same cycle as write returns old value
        @(negedge clk);
        bus_addr = A_SOCK; bus_wdata = 8'h15; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10", "same-cycle read old", 32'(bus_rdata), 32'(m_sock));
        model_write(A_SOCK, 8'h15);
        @(negedge clk);
        check("R10", "next-cycle read new", 32'(bus_rdata), 32'h15);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            logic [14:0] a;
            a = pool[$urandom_range(0, 9)];
            @(negedge clk);
            wp_switch = 1'($urandom_range(0, 1));
            dev_ready = ND'($urandom);
            dev_mask  = ND'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                do_write(a, 8'($urandom));
                check_outputs(tag_of(a));
            end else begin
                do_read(a, tag_of(a));
            end
        end

        // R1: mid-run reset clears everything
        do_write(A_CFG, 8'h04);
        do_write(A_SLEEP, 8'h3F);
        do_write(A_OPT, 8'h80);
        do_reset();
        check_outputs("R1");
        do_read(A_CFG, "R1");
        do_read(A_WPROT, "R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule